// File: doc/BRIEF.md
# Eight-Pin GPIO Bank with Change-Event Management Interrupt

This block drives and watches a bank of general-purpose pins. For each pin, a register bus sets the direction, the output level and whether an output drives both levels or only pulls low. The block turns these settings into a pad output-enable and a pad output value. Pin inputs pass through a synchronizer. While a pin is an input, any change of its level, rising or falling, latches a per-pin event flag.

Each flag has its own enable bit. The block ORs together every flag whose enable is set into a single system-management interrupt request. Software finds the pins that caused the request by reading the flag register. It acknowledges a pin by writing 1 to that pin's flag. Register writes take one cycle. Reads are combinational on the current index.

Top module: `gpio_evt_bank`

## Requirements
- R1: After a synchronous reset, every register reads 0, every pin is an input, `pad_oe` and `pad_out` are 0, and `smi_req` is 0.
- R2: Register indices on `bus_idx`, with bit n of each register belonging to pin n: 80h direction (1 = output), 81h output level, 82h drive mode (1 = push-pull, 0 = open drain), 83h synchronized pin level (read-only, writes ignored), 8Eh event enable, 8Fh event flags. Any other index reads 0 and writes to it are ignored. A write to an index takes effect at the clock edge where `bus_wr` is high.
- R3: If a pin is an input and its level changes in either direction, its flag bit sets. The flag reads 1 after the third rising edge, counted from the first edge at which the new level is present on `pad_in`.
- R4: A level change does not set a pin's flag while the direction register holds that pin as an output.
- R5: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. Reading the flags does not change them.
- R6: When a change event and a clearing write hit the same flag bit at the same edge, the bit ends up set.
- R7: `smi_req` is 1 exactly when some pin has both its flag bit and its enable bit set. It follows the registers with no extra delay.
- R8: An output pin in push-pull mode has `pad_oe` = 1 and `pad_out` equal to its output level.
- R9: An output pin in open-drain mode has `pad_out` = 0. Its `pad_oe` is 1 when the output level is 0 and 0 when the output level is 1.
- R10: An input pin has `pad_oe` = 0 and `pad_out` = 0. Its output level and drive mode bits have no effect on the pad.
- R11: No flag sets from the levels present on `pad_in` at and just after reset. Detection starts only once the synchronizer and the comparison register hold sampled values, so a pin held high through reset raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_idx | input | 8 | Register index for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 8 | Write data, bit n for pin n |
| bus_rdata | output | 8 | Read data for the current index |
| pad_in | input | 8 | Asynchronous pin levels from the pads |
| pad_oe | output | 8 | Pad output enable per pin |
| pad_out | output | 8 | Pad output value per pin |
| smi_req | output | 1 | Combined management interrupt request |

## Verification
The first test holds several pins high through reset. This separates correct warm-up from a detector that compares against reset values. The next test toggles a single pin and samples the flags at each of the three edges that follow. That pins down the latency and catches any extra or missing stage. Simultaneous rising and falling changes on several pins, and later changes on a bank split between inputs and outputs, show that both transition directions count and that the direction mask is applied. A pin already flagged is then toggled and cleared at the same edge, which separates set-priority from clear-priority. The last phase drives random pin toggles and writes to every index, including the read-only and unmapped ones. It compares the pads, the request and the read data against the model on every cycle.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int NPIN_DEF = 8;
    localparam int IDX_W    = 8;

    localparam logic [IDX_W-1:0] IX_DIR    = 8'h80;
    localparam logic [IDX_W-1:0] IX_LEVEL  = 8'h81;
    localparam logic [IDX_W-1:0] IX_MODE   = 8'h82;
    localparam logic [IDX_W-1:0] IX_PINS   = 8'h83;
    localparam logic [IDX_W-1:0] IX_EVT_EN = 8'h8E;
    localparam logic [IDX_W-1:0] IX_EVT_FL = 8'h8F;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DIR,
        SEL_LEVEL,
        SEL_MODE,
        SEL_PINS,
        SEL_EVT_EN,
        SEL_EVT_FL
    } reg_sel_e;

    // Per-pin configuration carried from the register file to the pad drivers.
    typedef struct packed {
        logic is_out;
        logic level;
        logic push_pull;
    } pin_cfg_t;

    typedef struct packed {
        logic oe;
        logic o;
    } pad_drv_t;

    function automatic reg_sel_e decode_idx(input logic [IDX_W-1:0] idx);
        reg_sel_e s;
        case (idx)
            IX_DIR:    s = SEL_DIR;
            IX_LEVEL:  s = SEL_LEVEL;
            IX_MODE:   s = SEL_MODE;
            IX_PINS:   s = SEL_PINS;
            IX_EVT_EN: s = SEL_EVT_EN;
            IX_EVT_FL: s = SEL_EVT_FL;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

    // Open drain only pulls low: the pad is enabled when the level is 0.
    function automatic pad_drv_t drive_of(input pin_cfg_t c);
        pad_drv_t d;
        if (!c.is_out) begin
            d.oe = 1'b0;
            d.o  = 1'b0;
        end else if (c.push_pull) begin
            d.oe = 1'b1;
            d.o  = c.level;
        end else begin
            d.oe = ~c.level;
            d.o  = 1'b0;
        end
        return d;
    endfunction

endpackage

// File: rtl/gpio_evt_sync.sv
module gpio_evt_sync
    import gpio_evt_pkg::*;
#(
    parameter int NPIN   = NPIN_DEF,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] lvl,
    output logic [NPIN-1:0] chg,
    output logic            armed
);
    localparam int WARM = STAGES + 1;
    localparam int CW   = $clog2(WARM + 1);

    logic [STAGES-1:0][NPIN-1:0] stg_q;
    logic [NPIN-1:0]             prev_q;
    logic [CW-1:0]               warm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= pad_in;
            for (int k = 1; k < STAGES; k++) begin
                stg_q[k] <= stg_q[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= stg_q[STAGES-1];
        end
    end

    // Counts edges until the last stage and the comparison register hold samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
        end else if (warm_q != CW'(WARM)) begin
            warm_q <= warm_q + CW'(1);
        end
    end

    assign armed = (warm_q == CW'(WARM));
    assign lvl   = stg_q[STAGES-1];
    assign chg   = armed ? (stg_q[STAGES-1] ^ prev_q) : '0;

    a_r11_cold_start: assert property (@(posedge clk) disable iff (rst)
        (warm_q == '0) |=> !armed);

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status
    import gpio_evt_pkg::*;
#(
    parameter int NPIN = NPIN_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] chg,
    input  logic [NPIN-1:0] is_out,
    input  logic [NPIN-1:0] clr,
    input  logic [NPIN-1:0] en,
    output logic [NPIN-1:0] flag_q,
    output logic            req
);
    logic [NPIN-1:0] hit;

    assign hit = chg & ~is_out;

    for (genvar i = 0; i < NPIN; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_q[i] <= 1'b0;
            end else if (hit[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr[i]) begin
                flag_q[i] <= 1'b0;
            end
        end

        a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
            (chg[i] && !is_out[i] && clr[i]) |=> flag_q[i]);

        a_r5_clear: assert property (@(posedge clk) disable iff (rst)
            (!chg[i] && clr[i]) |=> !flag_q[i]);

        a_r4_out_no_set: assert property (@(posedge clk) disable iff (rst)
            (is_out[i] && !flag_q[i]) |=> !flag_q[i]);

        a_r3_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_q[i]) |-> $past(chg[i]));
    end

    assign req = |(flag_q & en);

endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int NPIN = NPIN_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [IDX_W-1:0]           bus_idx,
    input  logic                       bus_wr,
    input  logic [NPIN-1:0]            bus_wdata,
    output logic [NPIN-1:0]            bus_rdata,
    input  logic [NPIN-1:0]            pin_lvl,
    input  logic [NPIN-1:0]            flag_q,
    output pin_cfg_t [NPIN-1:0]        cfg,
    output logic [NPIN-1:0]            dir_o,
    output logic [NPIN-1:0]            en_o,
    output logic [NPIN-1:0]            clr_o
);
    reg_sel_e        sel;
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] level_q;
    logic [NPIN-1:0] mode_q;
    logic [NPIN-1:0] en_q;

    assign sel = decode_idx(bus_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            level_q <= '0;
            mode_q  <= '0;
            en_q    <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_DIR:    dir_q   <= bus_wdata;
                SEL_LEVEL:  level_q <= bus_wdata;
                SEL_MODE:   mode_q  <= bus_wdata;
                SEL_EVT_EN: en_q    <= bus_wdata;
                default:    ;
            endcase
        end
    end

    assign clr_o = (bus_wr && sel == SEL_EVT_FL) ? bus_wdata : '0;

    always_comb begin
        case (sel)
            SEL_DIR:    bus_rdata = dir_q;
            SEL_LEVEL:  bus_rdata = level_q;
            SEL_MODE:   bus_rdata = mode_q;
            SEL_PINS:   bus_rdata = pin_lvl;
            SEL_EVT_EN: bus_rdata = en_q;
            SEL_EVT_FL: bus_rdata = flag_q;
            default:    bus_rdata = '0;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            cfg[i].is_out    = dir_q[i];
            cfg[i].level     = level_q[i];
            cfg[i].push_pull = mode_q[i];
        end
    end

    assign dir_o = dir_q;
    assign en_o  = en_q;

    a_r2_ro_pins: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_PINS) |=> ($stable(dir_q) && $stable(level_q)
                                          && $stable(mode_q) && $stable(en_q)));

endmodule

// File: rtl/gpio_evt_pad.sv
module gpio_evt_pad
    import gpio_evt_pkg::*;
#(
    parameter int NPIN = NPIN_DEF
) (
    input  pin_cfg_t [NPIN-1:0] cfg,
    output logic [NPIN-1:0]     pad_oe,
    output logic [NPIN-1:0]     pad_out
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pad_drv_t d;
        assign d          = drive_of(cfg[i]);
        assign pad_oe[i]  = d.oe;
        assign pad_out[i] = d.o;
    end
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank
    import gpio_evt_pkg::*;
#(
    parameter int NPIN       = NPIN_DEF,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic             bus_wr,
    input  logic [NPIN-1:0]  bus_wdata,
    output logic [NPIN-1:0]  bus_rdata,
    input  logic [NPIN-1:0]  pad_in,
    output logic [NPIN-1:0]  pad_oe,
    output logic [NPIN-1:0]  pad_out,
    output logic             smi_req
);
    pin_cfg_t [NPIN-1:0] cfg;
    logic [NPIN-1:0]     lvl;
    logic [NPIN-1:0]     chg;
    logic                armed;
    logic [NPIN-1:0]     dir;
    logic [NPIN-1:0]     en;
    logic [NPIN-1:0]     clr;
    logic [NPIN-1:0]     flag_q;

    gpio_evt_sync #(.NPIN(NPIN), .STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .lvl    (lvl),
        .chg    (chg),
        .armed  (armed)
    );

    gpio_evt_regs #(.NPIN(NPIN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_idx   (bus_idx),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_lvl   (lvl),
        .flag_q    (flag_q),
        .cfg       (cfg),
        .dir_o     (dir),
        .en_o      (en),
        .clr_o     (clr)
    );

    gpio_evt_status #(.NPIN(NPIN)) u_status (
        .clk    (clk),
        .rst    (rst),
        .chg    (chg),
        .is_out (dir),
        .clr    (clr),
        .en     (en),
        .flag_q (flag_q),
        .req    (smi_req)
    );

    gpio_evt_pad #(.NPIN(NPIN)) u_pad (
        .cfg     (cfg),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    a_r10_input_released: assert property (@(posedge clk) disable iff (rst)
        ((~dir & (pad_oe | pad_out)) == '0));

    a_r9_od_high_released: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & pad_out & ~bus_rdata & ~bus_rdata) == (pad_oe & pad_out & ~bus_rdata))
        && ((pad_out & ~pad_oe) == '0));

    a_r7_req_needs_enable: assert property (@(posedge clk) disable iff (rst)
        smi_req |-> (en != '0) && (flag_q != '0));

    a_r11_quiet_until_armed: assert property (@(posedge clk) disable iff (rst)
        !armed |=> $stable(flag_q) || (flag_q == '0));

endmodule

// File: tb/gpio_evt_bank_tb.sv
module gpio_evt_bank_tb;

    localparam logic [7:0] A_DIR = 8'h80, A_LVL = 8'h81, A_MODE = 8'h82,
                           A_PINS = 8'h83, A_EN = 8'h8E, A_FL = 8'h8F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_idx = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_oe, pad_out;
    logic       smi_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio_evt_bank u_dut (
        .clk(clk), .rst(rst), .bus_idx(bus_idx), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .smi_req(smi_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [7:0] m_dir = 0, m_lvl = 0, m_mode = 0, m_en = 0, m_fl = 0, m_pins = 0;
    logic [7:0] hist[$];

    function automatic logic [7:0] m_read(input logic [7:0] ix);
        case (ix)
            A_DIR:  return m_dir;
            A_LVL:  return m_lvl;
            A_MODE: return m_mode;
            A_PINS: return m_pins;
            A_EN:   return m_en;
            A_FL:   return m_fl;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [7:0] ev, clr;
        if (rst) begin
            m_dir = 0; m_lvl = 0; m_mode = 0; m_en = 0; m_fl = 0; m_pins = 0;
            hist.delete();
        end else begin
            ev = 8'h00;
            if (hist.size() >= 3)
                ev = (hist[hist.size()-2] ^ hist[hist.size()-3]) & ~m_dir;
            clr = (bus_wr && bus_idx == A_FL) ? bus_wdata : 8'h00;
            m_fl = (m_fl & ~clr) | ev;
            if (bus_wr) begin
                case (bus_idx)
                    A_DIR:  m_dir  = bus_wdata;
                    A_LVL:  m_lvl  = bus_wdata;
                    A_MODE: m_mode = bus_wdata;
                    A_EN:   m_en   = bus_wdata;
                    default: ;
                endcase
            end
            hist.push_back(pad_in);
            if (hist.size() > 4) void'(hist.pop_front());
            m_pins = (hist.size() >= 2) ? hist[hist.size()-2] : 8'h00;
        end
        #2;
        if (!rst && !done) begin
            chk((bus_idx == A_FL) ? "R3 R5 flag readback" : "R2 register read",
                bus_rdata, m_read(bus_idx));
            chk("R7 smi_req", smi_req, |(m_fl & m_en));
            chk("R8 R9 R10 pad_oe", pad_oe, m_dir & (m_mode | ~m_lvl));
            chk("R8 R9 R10 pad_out", pad_out, m_dir & m_mode & m_lvl);
        end
    end

    task automatic wr(input logic [7:0] ix, input logic [7:0] d);
        bus_wr = 1'b1; bus_idx = ix; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] ix, input logic [7:0] exp, input string tag);
        bus_idx = ix;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic steps(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] pick [7];
        pick = '{A_DIR, A_LVL, A_MODE, A_PINS, A_EN, A_FL, 8'h90};
        pad_in = 8'hA5;
        steps(3);
        rst = 1'b0;
        // R1: reset state
        rd(A_DIR, 8'h00, "R1 dir after reset");
        rd(A_MODE, 8'h00, "R1 mode after reset");
        rd(A_EN, 8'h00, "R1 enable after reset");
        chk("R1 pad_oe after reset", pad_oe, 8'h00);
        chk("R1 smi_req after reset", smi_req, 1'b0);
        // R11: levels held through reset raise nothing
        steps(6);
        rd(A_FL, 8'h00, "R11 no event from reset levels");
        rd(A_PINS, 8'hA5, "R2 pin level readback");
        wr(A_EN, 8'hFF);
        // R3: latency of a single falling change on pin 0
        pad_in = 8'hA4;
        steps(1); rd(A_FL, 8'h00, "R3 flag after first edge");
        steps(1); rd(A_FL, 8'h00, "R3 flag after second edge");
        steps(1); rd(A_FL, 8'h01, "R3 flag after third edge");
        chk("R7 request raised", smi_req, 1'b1);
        // R3: rising and falling together
        pad_in = pad_in ^ 8'h06;
        steps(4);
        rd(A_FL, 8'h07, "R3 both directions flagged");
        // R5: clearing rules
        wr(A_FL, 8'h02);
        rd(A_FL, 8'h05, "R5 write one clears");
        wr(A_FL, 8'h00);
        rd(A_FL, 8'h05, "R5 write zero no effect");
        steps(2);
        rd(A_FL, 8'h05, "R5 read does not clear");
        // R7: enable gating
        wr(A_EN, 8'h02);
        #1 chk("R7 masked request", smi_req, 1'b0);
        wr(A_EN, 8'h01);
        #1 chk("R7 enabled request", smi_req, 1'b1);
        // R4: outputs do not flag
        wr(A_FL, 8'hFF);
        wr(A_DIR, 8'hF0);
        pad_in = ~pad_in;
        steps(4);
        rd(A_FL, 8'h0F, "R4 only input pins flagged");
        // R6: set wins over clear at the same edge (pin 0 already set)
        pad_in = pad_in ^ 8'h01;
        steps(2);
        wr(A_FL, 8'h01);
        rd(A_FL, 8'h0F, "R6 set wins over clear");
        wr(A_FL, 8'h01);
        rd(A_FL, 8'h0E, "R5 later clear works");
        // R8 R9 R10: pad drive
        wr(A_LVL, 8'h5A);
        wr(A_MODE, 8'h3C);
        #1;
        chk("R8 R9 R10 pad_oe pattern", pad_oe, 8'hF0 & (8'h3C | ~8'h5A));
        chk("R8 R9 pad_out pattern", pad_out, 8'hF0 & 8'h3C & 8'h5A);
        // R2: read-only and unmapped indices
        wr(A_PINS, 8'h00);
        wr(8'h90, 8'hFF);
        rd(8'h90, 8'h00, "R2 unmapped reads zero");
        rd(A_DIR, 8'hF0, "R2 dir unchanged by stray writes");
        // Random traffic compared every cycle by the model
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            bus_wr = 1'b0;
            if ($urandom % 4 == 0) pad_in = pad_in ^ 8'($urandom);
            bus_idx = pick[$urandom % 7];
            if ($urandom % 3 == 0) begin
                bus_wr = 1'b1;
                bus_wdata = 8'($urandom);
            end
        end
        @(negedge clk);
        bus_wr = 1'b0;
        steps(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule